// File: doc/BRIEF.md
# TDM Transmit Slot Sequencer

This block drives one serial data pin of a time-division-multiplexed transmit link. A frame sync, sampled on a bit-clock enable, restarts a slot counter at slot 0. Every slot is a fixed number of bit periods long. A 32-bit enable mask selects the slots in which the block sends a word. At the start of each enabled slot the block moves a one-word holding buffer into a shift register and sends that word MSB first. In a disabled slot the block leaves the buffer alone and holds the pin in a selectable idle state.

Refilling the buffer is the job of an upstream DMA. The block requests each word one slot before the slot that needs it. The request jumps over any run of disabled slots, and it wraps into the next frame when the next enabled slot lies there. The block sets a sticky underrun flag when an enabled slot starts and the buffer was not refilled.

Top module: `tdm_tx_sequencer`

## Requirements
- R1: When `bit_en` and `fsync` are high in the same cycle, the block enters slot 0, bit 0. After that, each `bit_en` advances one bit. After `slot_bits` bits the block moves to the next slot. After slot `slot_count-1` it returns to slot 0, and a frame sync arriving mid-slot also restarts at slot 0.
- R2: In an enabled slot, the low `slot_bits` bits of the buffered word appear on `ser_out` MSB first, one bit per bit period. The first bit of slot 0 appears in the bit period that follows the frame sync.
- R3: The buffer is consumed only at the start of a slot whose bit in `slot_mask` (bit index = slot number) is 1. In a disabled slot the buffer stays untouched and the next enabled slot sends the next word written.
- R4: `ser_oe` is 1 throughout every enabled slot. In a disabled slot the pin follows `idle_mode`: 2'b00 and 2'b01 give `ser_oe`=0 (high impedance), 2'b10 drives 0, and 2'b11 drives 1.
- R5: `dreq` is a one-cycle pulse in the first cycle of bit 0 of slot S, issued exactly when slot S+1 is enabled. An active slot is therefore requested during the slot before it, whether that slot is enabled or not, and runs of disabled slots are skipped.
- R6: For the last slot (`slot_count-1`), the lookahead examines slot 0 of the next frame.
- R7: `underrun` is set when an enabled slot starts while the buffer has not been written since it was last consumed. Only reset clears it.
- R8: A buffer write in the same cycle as a slot-start load is kept for the next enabled slot. The load uses the previous contents, and the underrun decision uses the buffer state before that cycle.
- R9: After reset and before the first frame sync, no word is loaded and `dreq` stays 0. The pin shows the disabled-slot state selected by `idle_mode`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_en | input | 1 | One-cycle bit-clock enable |
| fsync | input | 1 | Frame sync, valid only together with `bit_en` |
| slot_mask | input | 32 | Per-slot enable, bit i for slot i |
| slot_count | input | 6 | Slots per frame, 2 to 32 |
| slot_bits | input | 6 | Bits per slot, 8 to 32 |
| idle_mode | input | 2 | Pin state in disabled slots |
| buf_wr | input | 1 | Holding-buffer write strobe |
| buf_data | input | 32 | Word to write, right-aligned |
| ser_out | output | 1 | Serial data |
| ser_oe | output | 1 | Output enable for the serial pin |
| dreq | output | 1 | Refill request pulse |
| underrun | output | 1 | Sticky underrun flag |

## Verification
The range assertions on the counters rely on three conditions. `slot_count`, `slot_bits` and `slot_mask` are held constant between resets. Their values stay inside the stated ranges. `fsync` is only raised together with `bit_en`. The bench reprograms the configuration only while reset is asserted, uses counts and widths inside the ranges, and drives both strobes in the same cycle. It also spaces bit enables two clocks apart, which gives the DMA model a free cycle to answer each request.

// File: rtl/tdm_tx_pkg.sv
`timescale 1ns/1ps
package tdm_tx_pkg;
  parameter int unsigned MAX_SLOTS = 32;
  parameter int unsigned WORD_W    = 32;
  localparam int unsigned IDX_W = $clog2(MAX_SLOTS);
  localparam int unsigned CNT_W = $clog2(MAX_SLOTS + 1);
  localparam int unsigned BIT_W = $clog2(WORD_W);
  localparam int unsigned LEN_W = $clog2(WORD_W + 1);

  typedef enum logic [1:0] {
    IDLE_FLOAT   = 2'b00,
    IDLE_FLOAT_B = 2'b01,
    IDLE_LOW     = 2'b10,
    IDLE_HIGH    = 2'b11
  } idle_mode_e;

  // slot index that follows s in a frame of n slots
  function automatic logic [IDX_W-1:0] slot_after(input logic [IDX_W-1:0] s,
                                                  input logic [CNT_W-1:0] n);
    return ((CNT_W'(s) + CNT_W'(1)) >= n) ? '0 : s + IDX_W'(1);
  endfunction

  // true on the final bit of a slot of len bits
  function automatic logic is_last_bit(input logic [BIT_W-1:0] b,
                                       input logic [LEN_W-1:0] len);
    return (LEN_W'(b) + LEN_W'(1)) >= len;
  endfunction

  // move a right-aligned word of len bits up to the MSB end
  function automatic logic [WORD_W-1:0] align_msb(input logic [WORD_W-1:0] w,
                                                  input logic [LEN_W-1:0] len);
    return w << (WORD_W - int'(len));
  endfunction
endpackage

// File: rtl/tdm_slot_counter.sv
`timescale 1ns/1ps
module tdm_slot_counter
  import tdm_tx_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_en,
  input  logic             fsync,
  input  logic [CNT_W-1:0] slot_count,
  input  logic [LEN_W-1:0] slot_bits,
  output logic             running,
  output logic [IDX_W-1:0] slot_q,
  output logic [BIT_W-1:0] bit_q,
  output logic             slot_start,
  output logic [IDX_W-1:0] next_slot
);
  logic wrap;

  assign wrap       = running && is_last_bit(bit_q, slot_bits);
  assign slot_start = bit_en && (fsync || wrap);
  assign next_slot  = fsync ? '0 : slot_after(slot_q, slot_count);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      running <= 1'b0;
      slot_q  <= '0;
      bit_q   <= '0;
    end else if (bit_en) begin
      if (slot_start) begin
        running <= 1'b1;
        slot_q  <= next_slot;
        bit_q   <= '0;
      end else if (running) begin
        bit_q <= bit_q + BIT_W'(1);
      end
    end
  end

  p_bit_in_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> (LEN_W'(bit_q) < slot_bits));
  p_slot_in_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> (CNT_W'(slot_q) < slot_count));
  p_fsync_restart_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && fsync) |=> (slot_q == '0 && bit_q == '0 && running));
endmodule

// File: rtl/tdm_lookahead.sv
`timescale 1ns/1ps
module tdm_lookahead
  import tdm_tx_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 slot_start,
  input  logic [IDX_W-1:0]     next_slot,
  input  logic [CNT_W-1:0]     slot_count,
  input  logic [MAX_SLOTS-1:0] slot_mask,
  output logic                 dreq
);
  logic [IDX_W-1:0] peek_slot;

  // the slot after the one now starting; wraps into the next frame
  assign peek_slot = slot_after(next_slot, slot_count);

  always_ff @(posedge clk) begin
    if (!rst_n) dreq <= 1'b0;
    else        dreq <= slot_start && slot_mask[peek_slot];
  end

  p_req_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    dreq |=> !dreq);
endmodule

// File: rtl/tdm_tx_shifter.sv
`timescale 1ns/1ps
module tdm_tx_shifter
  import tdm_tx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_en,
  input  logic              slot_start,
  input  logic              slot_enabled,
  input  logic [LEN_W-1:0]  slot_bits,
  input  logic              buf_wr,
  input  logic [WORD_W-1:0] buf_data,
  output logic              load,
  output logic              active,
  output logic              shift_msb,
  output logic              buf_full,
  output logic              underrun
);
  logic [WORD_W-1:0] buf_q;
  logic [WORD_W-1:0] shreg;

  assign load      = slot_start && slot_enabled;
  assign shift_msb = shreg[WORD_W-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      buf_q    <= '0;
      buf_full <= 1'b0;
      shreg    <= '0;
      active   <= 1'b0;
      underrun <= 1'b0;
    end else begin
      if (buf_wr) buf_q <= buf_data;
      if (buf_wr)     buf_full <= 1'b1;
      else if (load)  buf_full <= 1'b0;
      if (slot_start) active <= slot_enabled;
      if (load) begin
        shreg    <= align_msb(buf_q, slot_bits);
        underrun <= underrun || !buf_full;
      end else if (bit_en) begin
        shreg <= shreg << 1;
      end
    end
  end

  p_consume_on_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(buf_full) |-> $past(load));
  p_disabled_keeps_buf_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_start && !slot_enabled && !buf_wr) |=> $stable(buf_full));
  p_underrun_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    underrun |=> underrun);
  p_write_survives_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_wr && load) |=> buf_full);
endmodule

// File: rtl/tdm_tx_sequencer.sv
`timescale 1ns/1ps
module tdm_tx_sequencer
  import tdm_tx_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bit_en,
  input  logic                 fsync,
  input  logic [MAX_SLOTS-1:0] slot_mask,
  input  logic [CNT_W-1:0]     slot_count,
  input  logic [LEN_W-1:0]     slot_bits,
  input  logic [1:0]           idle_mode,
  input  logic                 buf_wr,
  input  logic [WORD_W-1:0]    buf_data,
  output logic                 ser_out,
  output logic                 ser_oe,
  output logic                 dreq,
  output logic                 underrun
);
  logic             running;
  logic [IDX_W-1:0] slot_q;
  logic [BIT_W-1:0] bit_q;
  logic             slot_start;
  logic [IDX_W-1:0] next_slot;
  logic             load;
  logic             active;
  logic             shift_msb;
  logic             buf_full;
  idle_mode_e       mode;

  assign mode = idle_mode_e'(idle_mode);

  tdm_slot_counter u_cnt (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .fsync(fsync),
    .slot_count(slot_count), .slot_bits(slot_bits),
    .running(running), .slot_q(slot_q), .bit_q(bit_q),
    .slot_start(slot_start), .next_slot(next_slot)
  );

  tdm_lookahead u_look (
    .clk(clk), .rst_n(rst_n), .slot_start(slot_start), .next_slot(next_slot),
    .slot_count(slot_count), .slot_mask(slot_mask), .dreq(dreq)
  );

  tdm_tx_shifter u_shift (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .slot_start(slot_start),
    .slot_enabled(slot_mask[next_slot]), .slot_bits(slot_bits),
    .buf_wr(buf_wr), .buf_data(buf_data), .load(load), .active(active),
    .shift_msb(shift_msb), .buf_full(buf_full), .underrun(underrun)
  );

  always_comb begin
    ser_oe  = 1'b1;
    ser_out = shift_msb;
    if (!active) begin
      unique case (mode)
        IDLE_LOW:  ser_out = 1'b0;
        IDLE_HIGH: ser_out = 1'b1;
        default: begin
          ser_oe  = 1'b0;
          ser_out = 1'b0;
        end
      endcase
    end
  end

  p_oe_enabled_slot_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (running && slot_mask[slot_q]) |-> ser_oe);
  p_req_first_bit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    dreq |-> (running && bit_q == '0));
  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !running |-> (!dreq && !active));
  p_load_at_slot_edge_r3: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (bit_q == '0 && active));
endmodule

// File: tb/tdm_tx_sequencer_test.sv
`timescale 1ns/1ps
module tdm_tx_sequencer_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bit_en = 1'b0;
  logic        fsync = 1'b0;
  logic [31:0] slot_mask = '0;
  logic [5:0]  slot_count = 6'd4;
  logic [5:0]  slot_bits = 6'd8;
  logic [1:0]  idle_mode = 2'b00;
  logic        buf_wr = 1'b0;
  logic [31:0] buf_data = '0;
  logic        ser_out, ser_oe, dreq, underrun;

  int checks = 0;
  int errors = 0;
  int kw = 0;
  int kc = 0;
  logic dma_on = 1'b1;

  always #4 clk = ~clk;

  tdm_tx_sequencer uut (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .fsync(fsync),
    .slot_mask(slot_mask), .slot_count(slot_count), .slot_bits(slot_bits),
    .idle_mode(idle_mode), .buf_wr(buf_wr), .buf_data(buf_data),
    .ser_out(ser_out), .ser_oe(ser_oe), .dreq(dreq), .underrun(underrun)
  );

  function automatic logic [31:0] wordval(input int k);
    return (32'h9E37_79B9 * (k + 3)) ^ (k << 7);
  endfunction

  task automatic chk(input logic ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // one bit-clock enable; outputs are stable 2 ns after the edge
  task automatic step(input logic fs, input logic cw, input logic [31:0] cwd);
    @(negedge clk);
    bit_en = 1'b1;
    fsync = fs;
    if (cw) begin buf_wr = 1'b1; buf_data = cwd; end
    @(posedge clk); #2;
    bit_en = 1'b0;
    fsync = 1'b0;
    buf_wr = 1'b0;
  endtask

  // idle cycle between enables; the DMA model answers a request here
  task automatic gap();
    if (dma_on && dreq) begin
      buf_wr = 1'b1;
      buf_data = wordval(kw);
      kw++;
    end
    @(posedge clk); #2;
    buf_wr = 1'b0;
  endtask

  task automatic write_now(input logic [31:0] d);
    @(negedge clk);
    buf_wr = 1'b1;
    buf_data = d;
    @(posedge clk); #2;
    buf_wr = 1'b0;
  endtask

  task automatic do_reset(input int cnt, input int bits, input logic [31:0] mask,
                          input logic [1:0] mode);
    rst_n = 1'b0;
    slot_count = 6'(cnt);
    slot_bits = 6'(bits);
    slot_mask = mask;
    idle_mode = mode;
    repeat (2) @(posedge clk);
    #2 rst_n = 1'b1;
    kw = 0;
    kc = 0;
  endtask

  task automatic run_config(input int cnt, input int bits, input logic [31:0] mask,
                            input logic [1:0] mode, input int frames);
    logic [31:0] cur;
    logic exp_act;
    logic exp_req;
    cur = '0;
    dma_on = 1'b1;
    do_reset(cnt, bits, mask, mode);
    chk(dreq == 1'b0 && underrun == 1'b0, "R7 reset state", {dreq, underrun}, 0);
    // R9: before any frame sync
    step(1'b0, 1'b0, 0);
    chk(ser_oe == mode[1], "R9 idle oe", ser_oe, mode[1]);
    if (mode[1]) chk(ser_out == mode[0], "R9 idle level", ser_out, mode[0]);
    chk(dreq == 1'b0, "R9 no request", dreq, 0);
    gap();
    if (mask[0]) begin
      write_now(wordval(kw));
      kw++;
    end
    for (int f = 0; f < frames; f++) begin
      for (int s = 0; s < cnt; s++) begin
        for (int b = 0; b < bits; b++) begin
          step(s == 0 && b == 0, 1'b0, 0);
          exp_act = mask[s];
          if (b == 0 && exp_act) begin
            cur = wordval(kc);
            kc++;
          end
          chk(ser_oe == (exp_act | mode[1]), "R4 output enable", ser_oe,
              exp_act | mode[1]);
          if (exp_act)
            chk(ser_out == cur[bits-1-b], (b == 0) ? "R3 word loaded" : "R2 data bit",
                ser_out, cur[bits-1-b]);
          else if (mode[1])
            chk(ser_out == mode[0], "R4 idle level", ser_out, mode[0]);
          exp_req = (b == 0) && mask[(s + 1) % cnt];
          chk(dreq == exp_req, (s == cnt - 1) ? "R6 wrap lookahead" : "R5 request timing",
              dreq, exp_req);
          gap();
        end
      end
    end
    chk(underrun == 1'b0, "R7 no underrun when fed", underrun, 0);
  endtask

  initial begin
    #(200000 * 8);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] wa;
    logic [31:0] wb;
    // near-exhaustive sweep: 4 slots of 8 bits, every mask and idle mode
    for (int m = 0; m < 16; m++)
      for (int md = 0; md < 4; md++)
        run_config(4, 8, 32'(m), 2'(md), 2);
    run_config(32, 8, 32'h8000_0011, 2'b10, 2);
    run_config(3, 32, 32'h5, 2'b11, 2);
    run_config(2, 8, 32'h2, 2'b01, 3);
    run_config(5, 12, 32'h12, 2'b10, 2);

    // R7: starve the buffer
    dma_on = 1'b0;
    do_reset(4, 8, 32'h3, 2'b00);
    write_now(wordval(0));
    for (int s = 0; s < 4; s++)
      for (int b = 0; b < 8; b++) begin
        step(s == 0 && b == 0, 1'b0, 0);
        if (s == 0 && b == 0) chk(underrun == 1'b0, "R7 fed slot", underrun, 0);
        if (s == 1 && b == 0) chk(underrun == 1'b1, "R7 starved slot", underrun, 1);
        gap();
      end
    for (int b = 0; b < 8; b++) begin
      step(b == 0, 1'b0, 0);
      gap();
    end
    chk(underrun == 1'b1, "R7 flag sticky", underrun, 1);

    // R8: write in the same cycle as the load
    wa = 32'h0000_00C5;
    wb = 32'h0000_003A;
    do_reset(2, 8, 32'h1, 2'b10);
    write_now(wa);
    for (int s = 0; s < 2; s++)
      for (int b = 0; b < 8; b++) begin
        step(s == 0 && b == 0, 1'b0, 0);
        gap();
      end
    step(1'b1, 1'b1, wb);
    chk(ser_out == wa[7], "R8 load uses old word", ser_out, wa[7]);
    chk(underrun == 1'b1, "R8 underrun from prior state", underrun, 1);
    gap();
    for (int k = 1; k < 16; k++) begin
      step(1'b0, 1'b0, 0);
      gap();
    end
    for (int b = 0; b < 8; b++) begin
      step(b == 0, 1'b0, 0);
      chk(ser_out == wb[7-b], "R8 kept word sent next", ser_out, wb[7-b]);
      gap();
    end

    // R1: frame sync in the middle of a slot restarts slot 0
    do_reset(4, 8, 32'h1, 2'b11);
    write_now(wa);
    for (int b = 0; b < 5; b++) begin
      step(b == 0, 1'b0, 0);
      gap();
    end
    write_now(wb);
    for (int b = 0; b < 8; b++) begin
      step(b == 0, 1'b0, 0);
      chk(ser_out == wb[7-b] && ser_oe, "R1 restart at slot 0", ser_out, wb[7-b]);
      gap();
    end
    step(1'b0, 1'b0, 0);
    chk(ser_out == 1'b1 && ser_oe == 1'b1, "R1 slot 1 after 8 bits", {ser_oe, ser_out}, 3);
    gap();

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule